// File: doc/BRIEF.md
# Filtered bandwidth usage monitor counter

This block measures memory traffic. Each memory transaction arrives as a single-cycle valid pulse. The pulse carries a byte count, a partition identifier and a monitoring group tag. A filter can require the partition identifier, the group tag, or both to equal programmed values. Only the transactions that pass the filter add their byte count to a live counter, and only while the monitor is enabled.

Alongside the live counter, the block keeps a snapshot register. A selectable event loads the snapshot: one of several external capture inputs, or a software write to a trigger address. The live counter can optionally be zeroed at the same moment. When the counter overflows, a sticky status bit is set and the block drives a level interrupt. The counter either wraps or freezes after an overflow. Counter and snapshot reads can be reported shifted right by a fixed scale amount.

Software sees five word addresses through a simple register port. Writes take effect on the clock edge. Reads return data combinationally from the current address.

Top module: `bwmon_top`

## Requirements
- R1: After reset the control word reads 0x00000042, the filter, counter and snapshot read 0, and `irq_o` is 0.
- R2: The control word (address 0) has these fields: enable at bit 31, capture selector at bits 30:28, clear-on-capture at bit 27, overflow status at bit 26, interrupt enable at bit 25, freeze at bit 24, scaling at bit 19, group match at bit 17, partition match at bit 16. Bits 23:20, 18 and 15:8 read 0, and bits 7:0 always read 0x42, so writing 0xFFFFFFFF reads back 0xFF0B0042.
- R3: While enable is 0, no transaction changes the counter.
- R4: The filter word (address 1) holds the match partition in bits 7:0 and the match group in bits 19:16. With partition match set, only transactions whose partition equals the filter partition are counted. With group match set, only transactions whose group equals the filter group are counted. With both cleared, every transaction is counted.
- R5: Selector value k, for k from 1 to EXT_NUM, copies the counter value before this cycle's increment into the snapshot (address 3) in the cycle that `ext_capt[k-1]` is 1.
- R6: Selector 0, and any value from EXT_NUM+1 to 6 (inputs not built), never changes the snapshot, whatever `ext_capt` does.
- R7: Selector 7 captures in the cycle of any write to address 4. Writes to address 4 capture under no other selector, and address 4 reads 0.
- R8: With clear-on-capture set, a capture zeroes the counter right after the copy. A transaction counted in the same cycle leaves the counter holding only that transaction's byte count.
- R9: A carry out of the counter sets the overflow status. The status stays 1 until a control write puts 0 in bit 26.
- R10: With freeze cleared, the counter wraps modulo 2^CNT_W. With freeze set, the counter keeps the wrapped sum of the overflowing add and ignores further transactions. The freeze lifts when a control write clears the status, or when software writes the counter.
- R11: `irq_o` is 1 exactly while the overflow status and the interrupt enable are both 1.
- R12: With scaling set, reads of the counter and the snapshot return the value shifted right by SCALE_SH bits. With scaling cleared, they return it unshifted.
- R13: A write to address 2 loads the counter with the written value, and this write takes precedence over a transaction in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_bytes | input | BYTES_W | Bytes moved by the transaction |
| txn_part | input | PART_W | Partition identifier of the transaction |
| txn_grp | input | GRP_W | Monitoring group tag of the transaction |
| ext_capt | input | EXT_NUM | External capture event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The hardest state to reach is an overflow that lines up with other events. Examples are an overflow under freeze followed by more traffic, an overflow in the same cycle as a capture with clear, and a status clear racing a new carry. The ports can only reach such a state with a counter sitting a few bytes below its top. The stimulus therefore writes the counter directly to values near 2^32 before it sends traffic, both in directed cases and as a frequent choice in the random phase. Each random cycle mixes transactions, external pulses, trigger writes and control rewrites, so same-cycle collisions occur often.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;

    localparam int          CTRL_W    = 32;
    localparam int          ADDR_W    = 3;
    localparam int          GRP_LSB   = 16;
    localparam int          OFL_BIT   = 26;
    localparam logic [7:0]  TYPE_CODE = 8'h42;

    typedef enum logic [2:0] {
        CAPT_NONE = 3'd0,
        CAPT_EXT1 = 3'd1,
        CAPT_EXT2 = 3'd2,
        CAPT_EXT3 = 3'd3,
        CAPT_EXT4 = 3'd4,
        CAPT_EXT5 = 3'd5,
        CAPT_EXT6 = 3'd6,
        CAPT_SW   = 3'd7
    } capt_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_FILT = 3'd1,
        REG_CNT  = 3'd2,
        REG_CAPT = 3'd3,
        REG_TRIG = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic      en;
        capt_sel_e sel;
        logic      crst;
        logic      ofl;
        logic      intr;
        logic      frz;
        logic      scl;
        logic      mgrp;
        logic      mpart;
    } ctrl_t;

    function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
        return {c.en, c.sel, c.crst, c.ofl, c.intr, c.frz, 4'b0000,
                c.scl, 1'b0, c.mgrp, c.mpart, 8'h00, TYPE_CODE};
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.en    = w[31];
        c.sel   = capt_sel_e'(w[30:28]);
        c.crst  = w[27];
        c.ofl   = w[OFL_BIT];
        c.intr  = w[25];
        c.frz   = w[24];
        c.scl   = w[19];
        c.mgrp  = w[17];
        c.mpart = w[16];
        return c;
    endfunction

endpackage

// File: rtl/bwmon_filter.sv
module bwmon_filter #(
    parameter int PART_W = 8,
    parameter int GRP_W  = 4
) (
    input  logic              txn_valid,
    input  logic [PART_W-1:0] txn_part,
    input  logic [GRP_W-1:0]  txn_grp,
    input  logic [PART_W-1:0] flt_part,
    input  logic [GRP_W-1:0]  flt_grp,
    input  logic              match_part,
    input  logic              match_grp,
    input  logic              enable,
    output logic              take_o
);
    logic part_ok;
    logic grp_ok;

    always_comb begin
        part_ok = !match_part || (txn_part == flt_part);
        grp_ok  = !match_grp  || (txn_grp  == flt_grp);
        take_o  = enable && txn_valid && part_ok && grp_ok;
    end
endmodule

// File: rtl/bwmon_capsel.sv
module bwmon_capsel
    import bwmon_pkg::*;
#(
    parameter int EXT_NUM = 4
) (
    input  capt_sel_e          sel,
    input  logic [EXT_NUM-1:0] ext_capt,
    input  logic               sw_trig,
    output logic               fire_o
);
    logic [EXT_NUM-1:0] ext_hit;

    for (genvar i = 0; i < EXT_NUM; i++) begin : g_src
        assign ext_hit[i] = ext_capt[i] && (sel == capt_sel_e'(i + 1));
    end

    assign fire_o = (|ext_hit) || ((sel == CAPT_SW) && sw_trig);
endmodule

// File: rtl/bwmon_counter.sv
module bwmon_counter #(
    parameter int CNT_W   = 32,
    parameter int BYTES_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc_take,
    input  logic [BYTES_W-1:0] inc_bytes,
    input  logic               capt_fire,
    input  logic               capt_clr,
    input  logic               frz_en,
    input  logic               frz_release,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   cnt_wdata,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CNT_W-1:0]   capt_q,
    output logic               frozen_q,
    output logic               ovf_o
);
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] addend;
    logic [CNT_W:0]   sum;

    always_comb begin
        base   = (capt_fire && capt_clr) ? '0 : cnt_q;
        addend = (inc_take && !(frozen_q && frz_en)) ? CNT_W'(inc_bytes) : '0;
        sum    = {1'b0, base} + {1'b0, addend};
        ovf_o  = sum[CNT_W] && !cnt_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            capt_q   <= '0;
            frozen_q <= 1'b0;
        end else begin
            cnt_q <= cnt_we ? cnt_wdata : sum[CNT_W-1:0];
            if (capt_fire) begin
                capt_q <= cnt_q;
            end
            if (ovf_o && frz_en) begin
                frozen_q <= 1'b1;
            end else if (cnt_we || frz_release) begin
                frozen_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bwmon_regs.sv
module bwmon_regs
    import bwmon_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int PART_W   = 8,
    parameter int GRP_W    = 4,
    parameter int SCALE_SH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CTRL_W-1:0]   reg_wdata,
    input  logic                ovf_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [CNT_W-1:0]    capt_i,
    output ctrl_t               ctrl_q,
    output logic [PART_W-1:0]   flt_part_q,
    output logic [GRP_W-1:0]    flt_grp_q,
    output logic [CTRL_W-1:0]   reg_rdata,
    output logic                irq_o,
    output logic                sw_trig_o,
    output logic                cnt_we_o,
    output logic                frz_release_o
);
    reg_addr_e addr;
    logic      ctrl_we;
    logic      filt_we;
    ctrl_t     ctrl_d;

    function automatic logic [CTRL_W-1:0] scaled(input logic [CNT_W-1:0] v, input logic en);
        logic [CNT_W-1:0] s;
        s = en ? (v >> SCALE_SH) : v;
        return CTRL_W'(s);
    endfunction

    always_comb begin
        addr          = reg_addr_e'(reg_addr);
        ctrl_we       = reg_we && (addr == REG_CTRL);
        filt_we       = reg_we && (addr == REG_FILT);
        cnt_we_o      = reg_we && (addr == REG_CNT);
        sw_trig_o     = reg_we && (addr == REG_TRIG);
        frz_release_o = ctrl_we && !reg_wdata[OFL_BIT];
        ctrl_d        = ctrl_we ? unpack_ctrl(reg_wdata) : ctrl_q;
        ctrl_d.ofl    = ctrl_d.ofl || ovf_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            flt_part_q <= '0;
            flt_grp_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (filt_we) begin
                flt_part_q <= reg_wdata[PART_W-1:0];
                flt_grp_q  <= reg_wdata[GRP_LSB +: GRP_W];
            end
        end
    end

    always_comb begin
        case (addr)
            REG_CTRL: reg_rdata = pack_ctrl(ctrl_q);
            REG_FILT: begin
                reg_rdata = '0;
                reg_rdata[PART_W-1:0]      = flt_part_q;
                reg_rdata[GRP_LSB +: GRP_W] = flt_grp_q;
            end
            REG_CNT:  reg_rdata = scaled(cnt_i, ctrl_q.scl);
            REG_CAPT: reg_rdata = scaled(capt_i, ctrl_q.scl);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_o = ctrl_q.ofl && ctrl_q.intr;
endmodule

// File: rtl/bwmon_top.sv
module bwmon_top
    import bwmon_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int BYTES_W  = 12,
    parameter int PART_W   = 8,
    parameter int GRP_W    = 4,
    parameter int EXT_NUM  = 4,
    parameter int SCALE_SH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_valid,
    input  logic [BYTES_W-1:0] txn_bytes,
    input  logic [PART_W-1:0]  txn_part,
    input  logic [GRP_W-1:0]   txn_grp,
    input  logic [EXT_NUM-1:0] ext_capt,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_o
);
    ctrl_t             ctrl_q;
    logic [PART_W-1:0] flt_part;
    logic [GRP_W-1:0]  flt_grp;
    logic              take;
    logic              capt_fire;
    logic              sw_trig;
    logic              cnt_we;
    logic              frz_release;
    logic              ovf_pulse;
    logic              frozen;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  capt_q;

    bwmon_regs #(
        .CNT_W(CNT_W), .PART_W(PART_W), .GRP_W(GRP_W), .SCALE_SH(SCALE_SH)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ovf_i(ovf_pulse), .cnt_i(cnt_q), .capt_i(capt_q),
        .ctrl_q(ctrl_q), .flt_part_q(flt_part), .flt_grp_q(flt_grp),
        .reg_rdata(reg_rdata), .irq_o(irq_o),
        .sw_trig_o(sw_trig), .cnt_we_o(cnt_we), .frz_release_o(frz_release)
    );

    bwmon_filter #(.PART_W(PART_W), .GRP_W(GRP_W)) u_filter (
        .txn_valid(txn_valid), .txn_part(txn_part), .txn_grp(txn_grp),
        .flt_part(flt_part), .flt_grp(flt_grp),
        .match_part(ctrl_q.mpart), .match_grp(ctrl_q.mgrp),
        .enable(ctrl_q.en), .take_o(take)
    );

    bwmon_capsel #(.EXT_NUM(EXT_NUM)) u_capsel (
        .sel(ctrl_q.sel), .ext_capt(ext_capt), .sw_trig(sw_trig), .fire_o(capt_fire)
    );

    bwmon_counter #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_counter (
        .clk(clk), .rst(rst),
        .inc_take(take), .inc_bytes(txn_bytes),
        .capt_fire(capt_fire), .capt_clr(ctrl_q.crst),
        .frz_en(ctrl_q.frz), .frz_release(frz_release),
        .cnt_we(cnt_we), .cnt_wdata(reg_wdata[CNT_W-1:0]),
        .cnt_q(cnt_q), .capt_q(capt_q), .frozen_q(frozen), .ovf_o(ovf_pulse)
    );
endmodule

// File: rtl/bwmon_chk.sv
module bwmon_chk
    import bwmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             irq_o,
    input ctrl_t            ctrl_q,
    input logic             capt_fire,
    input logic             ovf_pulse,
    input logic             frozen,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] capt_q
);
    logic cnt_wr;
    logic ctrl_wr;
    assign cnt_wr  = reg_we && (reg_addr == 3'd2);
    assign ctrl_wr = reg_we && (reg_addr == 3'd0);

    a_r3_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !cnt_wr && !capt_fire) |=> $stable(cnt_q));

    a_r5_capture_pre: assert property (@(posedge clk) disable iff (rst)
        capt_fire |=> (capt_q == $past(cnt_q)));

    a_r6_no_source: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.sel == CAPT_NONE) |-> !capt_fire);

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ofl && !ctrl_wr) |=> ctrl_q.ofl);

    a_r10_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (frozen && ctrl_q.frz && !cnt_wr && !capt_fire) |=> $stable(cnt_q));

    a_r11_irq_on_ovf: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && ctrl_q.intr && !ctrl_wr) |=> irq_o);

    a_r2_type_code: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd0) |-> (reg_rdata[7:0] == 8'h42));
endmodule

bind bwmon_top bwmon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .ctrl_q(ctrl_q),
    .capt_fire(capt_fire), .ovf_pulse(ovf_pulse), .frozen(frozen),
    .cnt_q(cnt_q), .capt_q(capt_q)
);

// File: tb/bwmon_top_tb.sv
module bwmon_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        txn_valid;
    logic [11:0] txn_bytes;
    logic [7:0]  txn_part;
    logic [3:0]  txn_grp;
    logic [3:0]  ext_capt;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the monitor state
    logic        m_en, m_crst, m_ofl, m_intr, m_frz, m_scl, m_mg, m_mp, m_frozen;
    logic [2:0]  m_sel;
    logic [7:0]  m_fpart;
    logic [3:0]  m_fgrp;
    logic [31:0] m_cnt, m_capt;

    always #10 clk = ~clk;

    bwmon_top u_dut (
        .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_bytes(txn_bytes),
        .txn_part(txn_part), .txn_grp(txn_grp), .ext_capt(ext_capt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] ctrl_word(logic en, logic [2:0] sel, logic crst,
            logic ofl, logic intr, logic frz, logic scl, logic mg, logic mp);
        return {en, sel, crst, ofl, intr, frz, 4'b0, scl, 1'b0, mg, mp, 8'h00, 8'h42};
    endfunction

    function automatic logic [31:0] m_ctrl();
        return ctrl_word(m_en, m_sel, m_crst, m_ofl, m_intr, m_frz, m_scl, m_mg, m_mp);
    endfunction

    function automatic logic [31:0] m_scaled(logic [31:0] v);
        return m_scl ? (v >> 4) : v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        {m_en, m_crst, m_ofl, m_intr, m_frz, m_scl, m_mg, m_mp, m_frozen} = '0;
        m_sel = 0; m_fpart = 0; m_fgrp = 0; m_cnt = 0; m_capt = 0;
    endtask

    // one clock with the given inputs; the model steps along with the design
    task automatic cyc(logic v, logic [11:0] b, logic [7:0] p, logic [3:0] g,
                       logic [3:0] e, logic we, logic [2:0] a, logic [31:0] wd);
        logic match, cen, capt, ovf, nfro, nofl;
        logic [32:0] sum;
        logic [31:0] base, ncnt, ncapt;
        @(negedge clk);
        txn_valid = v; txn_bytes = b; txn_part = p; txn_grp = g; ext_capt = e;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        match = (!m_mp || p == m_fpart) && (!m_mg || g == m_fgrp);
        cen   = m_en && v && match && !(m_frozen && m_frz);
        capt  = (m_sel == 3'd7 && we && a == 3'd4) ||
                (m_sel >= 3'd1 && m_sel <= 3'd4 && e[m_sel - 3'd1]);
        ncapt = capt ? m_cnt : m_capt;
        base  = (capt && m_crst) ? 32'd0 : m_cnt;
        sum   = {1'b0, base} + (cen ? {21'd0, b} : 33'd0);
        ovf   = sum[32] && !(we && a == 3'd2);
        ncnt  = (we && a == 3'd2) ? wd : sum[31:0];
        nfro  = m_frozen;
        if (we && a == 3'd2) nfro = 1'b0;
        if (we && a == 3'd0 && !wd[26]) nfro = 1'b0;
        if (ovf && m_frz) nfro = 1'b1;
        nofl = ((we && a == 3'd0) ? wd[26] : m_ofl) || ovf;
        @(posedge clk);
        #1;
        if (we && a == 3'd0) begin
            m_en = wd[31]; m_sel = wd[30:28]; m_crst = wd[27]; m_intr = wd[25];
            m_frz = wd[24]; m_scl = wd[19]; m_mg = wd[17]; m_mp = wd[16];
        end
        if (we && a == 3'd1) begin
            m_fpart = wd[7:0]; m_fgrp = wd[19:16];
        end
        m_ofl = nofl; m_frozen = nfro; m_cnt = ncnt; m_capt = ncapt;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] wd);
        cyc(0, 0, 0, 0, 0, 1, a, wd);
    endtask

    task automatic txn(logic [11:0] b, logic [7:0] p, logic [3:0] g);
        cyc(1, b, p, g, 0, 0, 0, 0);
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        txn_valid = 0; ext_capt = 0; reg_we = 0; reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        rd(3'd0, d); check({req, " ctrl"}, d, m_ctrl());
        rd(3'd2, d); check({req, " count"}, d, m_scaled(m_cnt));
        rd(3'd3, d); check({req, " snapshot"}, d, m_scaled(m_capt));
        check({req, " irq"}, {31'd0, irq_o}, {31'd0, m_ofl && m_intr});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'hB3C4_0011));
        rst = 1; txn_valid = 0; txn_bytes = 0; txn_part = 0; txn_grp = 0;
        ext_capt = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd(3'd0, d); check("R1 ctrl", d, 32'h0000_0042);
        rd(3'd1, d); check("R1 filter", d, 0);
        rd(3'd2, d); check("R1 count", d, 0);
        rd(3'd3, d); check("R1 snapshot", d, 0);
        check("R1 irq", {31'd0, irq_o}, 0);

        // R2 layout, reserved bits, type code; R11 irq with both bits set
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R2 all ones", d, 32'hFF0B_0042);
        check("R11 irq high", {31'd0, irq_o}, 1);
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, d); check("R2 cleared", d, 32'h0000_0042);
        check("R11 irq low", {31'd0, irq_o}, 0);
        rd(3'd4, d); check("R7 trigger reads zero", d, 0);

        // R3 disabled monitor ignores traffic
        wr(3'd2, 32'd0);
        txn(12'd100, 0, 0); txn(12'd55, 3, 2);
        rd(3'd2, d); check("R3 disabled count", d, 0);

        // R4 filtering
        wr(3'd1, {12'd0, 4'd2, 8'd0, 8'd5});
        rd(3'd1, d); check("R4 filter word", d, 32'h0002_0005);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 0, 0));
        txn(12'd10, 1, 1); txn(12'd20, 5, 7);
        rd(3'd2, d); check("R4 no match all counted", d, 30);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 0, 1));
        txn(12'd3, 5, 9); txn(12'd100, 6, 2);
        rd(3'd2, d); check("R4 partition match", d, 33);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 1, 1));
        txn(12'd4, 5, 2); txn(12'd200, 5, 3); txn(12'd200, 4, 2);
        rd(3'd2, d); check("R4 both match", d, 37);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 1, 0));
        txn(12'd1, 9, 2); txn(12'd300, 5, 1);
        rd(3'd2, d); check("R4 group match", d, 38);

        // R5 external capture takes pre-increment value
        wr(3'd0, ctrl_word(1, 2, 0, 0, 0, 0, 0, 0, 0));
        cyc(1, 12'd2, 0, 0, 4'b0010, 0, 0, 0);
        rd(3'd3, d); check("R5 ext2 snapshot", d, 38);
        rd(3'd2, d); check("R5 count after", d, 40);
        cyc(0, 0, 0, 0, 4'b1101, 0, 0, 0);
        rd(3'd3, d); check("R5 other inputs ignored", d, 38);

        // R6 unbuilt sources and selector 0
        wr(3'd0, ctrl_word(1, 5, 0, 0, 0, 0, 0, 0, 0));
        cyc(0, 0, 0, 0, 4'b1111, 0, 0, 0);
        wr(3'd0, ctrl_word(1, 6, 0, 0, 0, 0, 0, 0, 0));
        cyc(0, 0, 0, 0, 4'b1111, 0, 0, 0);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 0, 0));
        cyc(0, 0, 0, 0, 4'b1111, 0, 0, 0);
        rd(3'd3, d); check("R6 no capture", d, 38);

        // R7 software trigger
        wr(3'd0, ctrl_word(1, 1, 0, 0, 0, 0, 0, 0, 0));
        wr(3'd4, 32'd1);
        rd(3'd3, d); check("R7 trigger under ext1 ignored", d, 38);
        wr(3'd0, ctrl_word(1, 7, 0, 0, 0, 0, 0, 0, 0));
        wr(3'd4, 32'd0);
        rd(3'd3, d); check("R7 trigger capture", d, 40);

        // R8 capture with clear and a same-cycle transaction
        wr(3'd2, 32'd100);
        wr(3'd0, ctrl_word(1, 1, 1, 0, 0, 0, 0, 0, 0));
        cyc(1, 12'd7, 0, 0, 4'b0001, 0, 0, 0);
        rd(3'd3, d); check("R8 snapshot", d, 100);
        rd(3'd2, d); check("R8 count only new bytes", d, 7);

        // R13 counter write beats a same-cycle transaction
        cyc(1, 12'd50, 0, 0, 0, 1, 3'd2, 32'h0000_1000);
        rd(3'd2, d); check("R13 write wins", d, 32'h0000_1000);

        // R9 R10 wrap
        wr(3'd0, ctrl_word(1, 0, 0, 0, 1, 0, 0, 0, 0));
        wr(3'd2, 32'hFFFF_FFFE);
        txn(12'd5, 0, 0);
        rd(3'd2, d); check("R10 wrap", d, 3);
        rd(3'd0, d); check("R9 status set", d[26], 1);
        check("R11 irq on overflow", {31'd0, irq_o}, 1);
        txn(12'd1, 0, 0);
        rd(3'd2, d); check("R10 counts after wrap", d, 4);
        rd(3'd0, d); check("R9 status sticky", d[26], 1);
        wr(3'd0, ctrl_word(1, 0, 0, 1, 0, 0, 0, 0, 0));
        check("R11 irq off with enable low", {31'd0, irq_o}, 0);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 0, 0));
        rd(3'd0, d); check("R9 status cleared", d[26], 0);

        // R10 freeze
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 1, 0, 0, 0));
        wr(3'd2, 32'hFFFF_FFFF);
        txn(12'd1, 0, 0); txn(12'd9, 0, 0);
        rd(3'd2, d); check("R10 freeze at zero", d, 0);
        wr(3'd0, ctrl_word(1, 0, 0, 0, 0, 1, 0, 0, 0));
        txn(12'd3, 0, 0);
        rd(3'd2, d); check("R10 unfreeze on clear", d, 3);
        wr(3'd2, 32'hFFFF_FFF0);
        txn(12'h020, 0, 0); txn(12'd5, 0, 0);
        rd(3'd2, d); check("R10 freeze wrapped sum", d, 32'h10);
        wr(3'd2, 32'd8);
        txn(12'd2, 0, 0);
        rd(3'd2, d); check("R10 unfreeze on count write", d, 10);

        // R12 scaling
        wr(3'd0, ctrl_word(1, 7, 0, 0, 0, 0, 1, 0, 0));
        wr(3'd2, 32'h0001_2345);
        wr(3'd4, 0);
        rd(3'd2, d); check("R12 scaled count", d, 32'h0000_1234);
        rd(3'd3, d); check("R12 scaled snapshot", d, 32'h0000_1234);
        wr(3'd0, ctrl_word(1, 7, 0, 0, 0, 0, 0, 0, 0));
        rd(3'd2, d); check("R12 raw count", d, 32'h0001_2345);

        // random phase, R3 R4 R5 R8 R9 R10 R11 against the model
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 6) begin
                logic [31:0] w;
                w = $urandom;
                if ($urandom_range(0, 3) != 0) w[31] = 1'b1;
                wr(3'd0, w);
            end else if (k < 9) begin
                wr(3'd1, {12'd0, 4'($urandom_range(0, 3)), 8'd0, 8'($urandom_range(0, 3))});
            end else if (k < 14) begin
                wr(3'd2, 32'hFFFF_F000 + $urandom_range(0, 32'hFFF));
            end else if (k < 16) begin
                wr(3'd4, $urandom);
            end else begin
                cyc($urandom_range(0, 3) != 0, 12'($urandom), 8'($urandom_range(0, 3)),
                    4'($urandom_range(0, 3)), 4'($urandom_range(0, 15) < 3 ? $urandom : 0),
                    0, 0, 0);
            end
            if (i % 25 == 24) check_all("R10 random");
        end
        check_all("R9 random end");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule